// File: doc/BRIEF.md
# Stream Lane Width Converter

This block moves a valid/ready byte-lane stream between two buses that share one lane width but carry different numbers of lanes. When the output has more lanes than the input, consecutive input beats are gathered into one wide output beat. When the output has fewer lanes, each wide input beat is handed out as a series of narrow beats. Every beat carries data, a per-lane keep mask, an end-of-packet flag and a user sideband. The lane width and both lane counts are parameters. A lane-count pair whose larger value is not a whole multiple of the smaller value stops elaboration with an error.

Both sides follow valid/ready rules. A beat transfers on a rising clock edge where valid and ready are both high. Once the block raises its output valid, it holds that beat unchanged until ready is seen. Input ready is computed from internal state and the output ready only. It never depends on input valid. Waiting always happens on the wide side. Wide-side valid stays low while narrow beats are being gathered, and wide-side ready stays low while narrow beats are being handed out. Narrow lane 0 always lines up with the lowest lanes of the wide word.

Top module: `stream_lane_converter`

## Requirements
- R1: Upsizing by a factor K: narrow beat number k of a wide word is placed in wide lanes k*IN_LANES up to k*IN_LANES+IN_LANES-1, together with its keep bits. Beat 0 sits at the least significant end. After K narrow beats, one wide beat is presented with those beats' data and keep.
- R2: Upsizing: a narrow beat with last set closes the wide word early. The wide beat then carries last=1, and every lane group that no narrow beat filled has keep 0 and data 0.
- R3: Upsizing: the wide beat's user value is the user value of the final narrow beat gathered into it.
- R4: Upsizing: wide valid is low while lanes are being gathered. It rises on the cycle after the closing narrow beat is accepted. Narrow ready is low only while a wide beat is waiting for output ready.
- R5: Downsizing: a wide beat is handed out in ascending lane-group order, one narrow beat per accepted output transfer. Wide ready stays low until the final narrow beat of the word is being taken.
- R6: Downsizing: a lane group whose keep bits are all 0 is skipped. Last is asserted only on the final group that has a set keep bit, and only when the wide beat carried last.
- R7: Downsizing: every narrow beat repeats the user value of its wide beat.
- R8: Downsizing: a wide beat with all keep bits 0 and last=0 produces no output. The same beat with last=1 produces one narrow beat from lane group 0, with keep 0 and last=1.
- R9: With equal lane counts, output data, keep, last, user and valid equal the inputs in the same cycle, and input ready equals output ready.
- R10: While output valid is high and output ready is low, output valid stays high and output data, keep, last and user stay unchanged.
- R11: After reset, output valid is 0 and input ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | IN_LANES*LANE_W | Input beat data, lane 0 in the low bits |
| s_keep | input | IN_LANES | Input lane keep mask |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_last | input | 1 | Input end-of-packet |
| s_user | input | USER_W | Input sideband |
| m_data | output | OUT_LANES*LANE_W | Output beat data, lane 0 in the low bits |
| m_keep | output | OUT_LANES | Output lane keep mask |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_last | output | 1 | Output end-of-packet |
| m_user | output | USER_W | Output sideband |

## Verification
The hardest case to reach is an upsized wide word that leaves the block on the same edge as the first narrow beat of the next word enters. In that case the gathering buffer has to be cleared and refilled at once. The stimulus stalls the output until a full word sits waiting with the next beat already offered. It then releases ready for one cycle and checks the content of the following word. On the downsizing side, sparse keep patterns are used to skip interior and leading lane groups, and all-empty words are sent with and without last.

// File: rtl/lane_conv_pkg.sv
package lane_conv_pkg;

  typedef enum logic [1:0] {
    CONV_PASS,
    CONV_PACK,
    CONV_SPLIT
  } conv_mode_e;

  function automatic conv_mode_e pick_mode(input int in_lanes, input int out_lanes);
    if (in_lanes == out_lanes) return CONV_PASS;
    if (in_lanes < out_lanes) return CONV_PACK;
    return CONV_SPLIT;
  endfunction

endpackage

// File: rtl/lane_packer.sv
module lane_packer #(
  parameter int LANE_W       = 8,
  parameter int NARROW_LANES = 2,
  parameter int RATIO        = 4,
  parameter int USER_W       = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NARROW_LANES*LANE_W-1:0]       s_data,
  input  logic [NARROW_LANES-1:0]              s_keep,
  input  logic                                 s_valid,
  output logic                                 s_ready,
  input  logic                                 s_last,
  input  logic [USER_W-1:0]                    s_user,
  output logic [NARROW_LANES*RATIO*LANE_W-1:0] m_data,
  output logic [NARROW_LANES*RATIO-1:0]        m_keep,
  output logic                                 m_valid,
  input  logic                                 m_ready,
  output logic                                 m_last,
  output logic [USER_W-1:0]                    m_user
);
  localparam int SEG_W      = NARROW_LANES * LANE_W;
  localparam int WIDE_LANES = NARROW_LANES * RATIO;
  localparam int IDX_W      = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [WIDE_LANES*LANE_W-1:0] data_q, data_n;
  logic [WIDE_LANES-1:0]        keep_q, keep_n;
  logic [USER_W-1:0]            user_q;
  logic                         last_q, valid_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         take, emit, closing;

  assign s_ready = !valid_q || m_ready;
  assign take    = s_valid && s_ready;
  assign emit    = valid_q && m_ready;
  assign closing = take && (s_last || (idx_q == IDX_W'(RATIO - 1)));

  always_comb begin
    data_n = emit ? '0 : data_q;
    keep_n = emit ? '0 : keep_q;
    if (take) begin
      data_n[idx_q*SEG_W +: SEG_W]               = s_data;
      keep_n[idx_q*NARROW_LANES +: NARROW_LANES] = s_keep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      keep_q  <= '0;
      user_q  <= '0;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      data_q <= data_n;
      keep_q <= keep_n;
      if (take) begin
        user_q <= s_user;
        last_q <= s_last;
        idx_q  <= closing ? '0 : idx_q + 1'b1;
      end
      if (closing)   valid_q <= 1'b1;
      else if (emit) valid_q <= 1'b0;
    end
  end

  assign m_data  = data_q;
  assign m_keep  = keep_q;
  assign m_valid = valid_q;
  assign m_last  = last_q;
  assign m_user  = user_q;
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter #(
  parameter int LANE_W       = 8,
  parameter int NARROW_LANES = 2,
  parameter int RATIO        = 4,
  parameter int USER_W       = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NARROW_LANES*RATIO*LANE_W-1:0] s_data,
  input  logic [NARROW_LANES*RATIO-1:0]        s_keep,
  input  logic                                 s_valid,
  output logic                                 s_ready,
  input  logic                                 s_last,
  input  logic [USER_W-1:0]                    s_user,
  output logic [NARROW_LANES*LANE_W-1:0]       m_data,
  output logic [NARROW_LANES-1:0]              m_keep,
  output logic                                 m_valid,
  input  logic                                 m_ready,
  output logic                                 m_last,
  output logic [USER_W-1:0]                    m_user
);
  localparam int SEG_W      = NARROW_LANES * LANE_W;
  localparam int WIDE_LANES = NARROW_LANES * RATIO;
  localparam int IDX_W      = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [WIDE_LANES*LANE_W-1:0] hold_data;
  logic [WIDE_LANES-1:0]        hold_keep;
  logic [USER_W-1:0]            hold_user;
  logic                         hold_last, hold_valid;
  logic [IDX_W-1:0]             idx_q;

  logic [RATIO-1:0] nz_hold, nz_in;
  logic [IDX_W-1:0] next_idx, first_idx;
  logic             has_next, any_in, take, give;

  always_comb begin
    for (int j = 0; j < RATIO; j++) begin
      nz_hold[j] = |hold_keep[j*NARROW_LANES +: NARROW_LANES];
      nz_in[j]   = |s_keep[j*NARROW_LANES +: NARROW_LANES];
    end
    has_next  = 1'b0;
    next_idx  = idx_q;
    any_in    = 1'b0;
    first_idx = '0;
    for (int j = RATIO - 1; j >= 0; j--) begin
      if (nz_hold[j] && (j > int'(idx_q))) begin
        has_next = 1'b1;
        next_idx = IDX_W'(j);
      end
      if (nz_in[j]) begin
        any_in    = 1'b1;
        first_idx = IDX_W'(j);
      end
    end
  end

  assign s_ready = !hold_valid || (m_ready && !has_next);
  assign take    = s_valid && s_ready;
  assign give    = hold_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_keep  <= '0;
      hold_user  <= '0;
      hold_last  <= 1'b0;
      hold_valid <= 1'b0;
      idx_q      <= '0;
    end else if (take) begin
      hold_data  <= s_data;
      hold_keep  <= s_keep;
      hold_user  <= s_user;
      hold_last  <= s_last;
      hold_valid <= any_in || s_last;
      idx_q      <= first_idx;
    end else if (give) begin
      if (has_next) idx_q <= next_idx;
      else          hold_valid <= 1'b0;
    end
  end

  assign m_data  = hold_data[idx_q*SEG_W +: SEG_W];
  assign m_keep  = hold_keep[idx_q*NARROW_LANES +: NARROW_LANES];
  assign m_valid = hold_valid;
  assign m_last  = hold_last && !has_next;
  assign m_user  = hold_user;
endmodule

// File: rtl/stream_lane_converter.sv
module stream_lane_converter
  import lane_conv_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 8,
  parameter int USER_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IN_LANES*LANE_W-1:0]  s_data,
  input  logic [IN_LANES-1:0]         s_keep,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic                        s_last,
  input  logic [USER_W-1:0]           s_user,
  output logic [OUT_LANES*LANE_W-1:0] m_data,
  output logic [OUT_LANES-1:0]        m_keep,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic                        m_last,
  output logic [USER_W-1:0]           m_user
);
  localparam conv_mode_e MODE = pick_mode(IN_LANES, OUT_LANES);
  localparam int NARROW = (IN_LANES < OUT_LANES) ? IN_LANES : OUT_LANES;
  localparam int WIDE   = (IN_LANES < OUT_LANES) ? OUT_LANES : IN_LANES;
  localparam int RATIO  = WIDE / NARROW;

  if (WIDE % NARROW != 0) begin : g_bad_ratio
    $error("lane counts must be whole multiples of each other");
  end

  if (MODE == CONV_PASS) begin : g_pass
    assign m_data  = s_data;
    assign m_keep  = s_keep;
    assign m_valid = s_valid;
    assign m_last  = s_last;
    assign m_user  = s_user;
    assign s_ready = m_ready;
  end else if (MODE == CONV_PACK) begin : g_pack
    lane_packer #(
      .LANE_W(LANE_W), .NARROW_LANES(NARROW), .RATIO(RATIO), .USER_W(USER_W)
    ) u_pack (
      .clk(clk), .rst_n(rst_n),
      .s_data(s_data), .s_keep(s_keep), .s_valid(s_valid), .s_ready(s_ready),
      .s_last(s_last), .s_user(s_user),
      .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid), .m_ready(m_ready),
      .m_last(m_last), .m_user(m_user)
    );
  end else begin : g_split
    lane_splitter #(
      .LANE_W(LANE_W), .NARROW_LANES(NARROW), .RATIO(RATIO), .USER_W(USER_W)
    ) u_split (
      .clk(clk), .rst_n(rst_n),
      .s_data(s_data), .s_keep(s_keep), .s_valid(s_valid), .s_ready(s_ready),
      .s_last(s_last), .s_user(s_user),
      .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid), .m_ready(m_ready),
      .m_last(m_last), .m_user(m_user)
    );
  end
endmodule

// File: rtl/lane_conv_checker.sv
module lane_conv_checker
  import lane_conv_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 8,
  parameter int USER_W    = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        s_valid,
  input logic                        s_ready,
  input logic                        s_last,
  input logic [OUT_LANES*LANE_W-1:0] m_data,
  input logic [OUT_LANES-1:0]        m_keep,
  input logic                        m_valid,
  input logic                        m_ready,
  input logic                        m_last,
  input logic [USER_W-1:0]           m_user
);
  localparam conv_mode_e MODE = pick_mode(IN_LANES, OUT_LANES);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep)
                               && $stable(m_last) && $stable(m_user))); // R10

  if (MODE == CONV_PACK) begin : g_pack_chk
    AST_PACK_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ready |-> (m_valid && !m_ready)); // R4
    AST_PACK_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready) |=> (!m_valid || $past(s_valid && s_ready))); // R4
    AST_PACK_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && s_last) |=> (m_valid && m_last)); // R2
  end else if (MODE == CONV_SPLIT) begin : g_split_chk
    AST_SPLIT_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ready |-> m_valid); // R5
    AST_SPLIT_EMPTY_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && (m_keep == '0)) |-> m_last); // R8
    AST_SPLIT_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && m_last) |-> s_ready); // R5
    AST_SPLIT_LAST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && s_last) |=> m_valid); // R8
  end else begin : g_pass_chk
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid == s_valid) && (m_last == s_last) && (s_ready == m_ready)); // R9
  end
endmodule

bind stream_lane_converter lane_conv_checker #(
  .LANE_W(LANE_W), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES), .USER_W(USER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid), .m_ready(m_ready),
  .m_last(m_last), .m_user(m_user)
);

// File: tb/stream_lane_converter_tb_top.sv
`timescale 1ns/1ps
module stream_lane_converter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // upsizer 2 -> 8 lanes
  logic [15:0] u_s_data;  logic [1:0] u_s_keep; logic u_s_valid, u_s_ready, u_s_last;
  logic [1:0]  u_s_user;
  logic [63:0] u_m_data;  logic [7:0] u_m_keep; logic u_m_valid, u_m_ready, u_m_last;
  logic [1:0]  u_m_user;
  // downsizer 8 -> 2 lanes
  logic [63:0] d_s_data;  logic [7:0] d_s_keep; logic d_s_valid, d_s_ready, d_s_last;
  logic [1:0]  d_s_user;
  logic [15:0] d_m_data;  logic [1:0] d_m_keep; logic d_m_valid, d_m_ready, d_m_last;
  logic [1:0]  d_m_user;
  // equal 4 -> 4 lanes
  logic [31:0] e_s_data;  logic [3:0] e_s_keep; logic e_s_valid, e_s_ready, e_s_last;
  logic [1:0]  e_s_user;
  logic [31:0] e_m_data;  logic [3:0] e_m_keep; logic e_m_valid, e_m_ready, e_m_last;
  logic [1:0]  e_m_user;

  stream_lane_converter #(.LANE_W(8), .IN_LANES(2), .OUT_LANES(8), .USER_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_data(u_s_data), .s_keep(u_s_keep), .s_valid(u_s_valid),
    .s_ready(u_s_ready), .s_last(u_s_last), .s_user(u_s_user), .m_data(u_m_data),
    .m_keep(u_m_keep), .m_valid(u_m_valid), .m_ready(u_m_ready), .m_last(u_m_last),
    .m_user(u_m_user));

  stream_lane_converter #(.LANE_W(8), .IN_LANES(8), .OUT_LANES(2), .USER_W(2)) dut_dn_i (
    .clk(clk), .rst_n(rst_n), .s_data(d_s_data), .s_keep(d_s_keep), .s_valid(d_s_valid),
    .s_ready(d_s_ready), .s_last(d_s_last), .s_user(d_s_user), .m_data(d_m_data),
    .m_keep(d_m_keep), .m_valid(d_m_valid), .m_ready(d_m_ready), .m_last(d_m_last),
    .m_user(d_m_user));

  stream_lane_converter #(.LANE_W(8), .IN_LANES(4), .OUT_LANES(4), .USER_W(2)) dut_eq_i (
    .clk(clk), .rst_n(rst_n), .s_data(e_s_data), .s_keep(e_s_keep), .s_valid(e_s_valid),
    .s_ready(e_s_ready), .s_last(e_s_last), .s_user(e_s_user), .m_data(e_m_data),
    .m_keep(e_m_keep), .m_valid(e_m_valid), .m_ready(e_m_ready), .m_last(e_m_last),
    .m_user(e_m_user));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic up_drive(input logic [15:0] d, input logic [1:0] k, input logic l,
                          input logic [1:0] usr);
    u_s_valid = 1'b1; u_s_data = d; u_s_keep = k; u_s_last = l; u_s_user = usr;
  endtask

  task automatic up_idle();
    u_s_valid = 1'b0; u_s_data = '0; u_s_keep = '0; u_s_last = 1'b0; u_s_user = '0;
  endtask

  task automatic test_reset();
    check("R11 up m_valid", 64'(u_m_valid), 64'd0);
    check("R11 up s_ready", 64'(u_s_ready), 64'd1);
    check("R11 dn m_valid", 64'(d_m_valid), 64'd0);
    check("R11 dn s_ready", 64'(d_s_ready), 64'd1);
  endtask

  task automatic test_up_full();
    logic [63:0] exp = '0;
    u_m_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] b = 16'hA1A0 + 16'(k) * 16'h0202;
      exp[k*16 +: 16] = b;
      up_drive(b, 2'b11, 1'b0, 2'(k));
      #1;
      check("R4 gathering m_valid low", 64'(u_m_valid), 64'd0);
      check("R4 gathering s_ready", 64'(u_s_ready), 64'd1);
      step();
    end
    up_idle();
    #1;
    check("R4 word valid", 64'(u_m_valid), 64'd1);
    check("R1 packed data", u_m_data, exp);
    check("R1 packed keep", 64'(u_m_keep), 64'hFF);
    check("R1 no last", 64'(u_m_last), 64'd0);
    check("R3 user from final beat", 64'(u_m_user), 64'd3);
    step();
    #1;
    check("R4 valid drops after take", 64'(u_m_valid), 64'd0);
  endtask

  task automatic test_up_early_last();
    u_m_ready = 1'b1;
    up_drive(16'hB1B0, 2'b11, 1'b0, 2'd2); step();
    up_drive(16'h55B2, 2'b01, 1'b1, 2'd1); step();
    up_idle();
    #1;
    check("R2 early close valid", 64'(u_m_valid), 64'd1);
    check("R2 early close data", u_m_data, 64'h0000_0000_55B2_B1B0);
    check("R2 early close keep", 64'(u_m_keep), 64'h07);
    check("R2 early close last", 64'(u_m_last), 64'd1);
    check("R3 user of closing beat", 64'(u_m_user), 64'd1);
    step();
  endtask

  task automatic test_up_backpressure();
    logic [63:0] held;
    u_m_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      up_drive(16'hC1C0 + 16'(k) * 16'h0202, 2'b11, k == 3, 2'd0);
      step();
    end
    up_drive(16'hD1D0, 2'b11, 1'b0, 2'd1);
    #1;
    held = u_m_data;
    check("R10 held data", held, 64'hC7C6_C5C4_C3C2_C1C0);
    for (int c = 0; c < 3; c++) begin
      check("R4 stalled s_ready low", 64'(u_s_ready), 64'd0);
      check("R10 valid held", 64'(u_m_valid), 64'd1);
      check("R10 data stable", u_m_data, held);
      check("R10 last stable", 64'(u_m_last), 64'd1);
      step();
      #1;
    end
    u_m_ready = 1'b1;
    #1;
    check("R4 ready follows release", 64'(u_s_ready), 64'd1);
    step();
    for (int k = 1; k < 4; k++) begin
      up_drive(16'hD1D0 + 16'(k) * 16'h0202, 2'b11, k == 3, 2'd2);
      #1;
      check("R4 refill m_valid low", 64'(u_m_valid), 64'd0);
      step();
    end
    up_idle();
    #1;
    check("R1 word after overlap", u_m_data, 64'hD7D6_D5D4_D3D2_D1D0);
    check("R1 keep after overlap", 64'(u_m_keep), 64'hFF);
    step();
  endtask

  task automatic dn_load(input logic [63:0] d, input logic [7:0] k, input logic l,
                         input logic [1:0] usr);
    d_s_valid = 1'b1; d_s_data = d; d_s_keep = k; d_s_last = l; d_s_user = usr;
    #1;
    check("R5 wide ready when idle", 64'(d_s_ready), 64'd1);
    step();
    d_s_valid = 1'b0; d_s_data = '0; d_s_keep = '0; d_s_last = 1'b0; d_s_user = '0;
  endtask

  task automatic dn_expect(input string req, input logic [15:0] d, input logic [1:0] k,
                           input logic l, input logic [1:0] usr, input logic rdy);
    #1;
    check({req, " valid"}, 64'(d_m_valid), 64'd1);
    check({req, " data"}, 64'(d_m_data), 64'(d));
    check({req, " keep"}, 64'(d_m_keep), 64'(k));
    check({req, " last"}, 64'(d_m_last), 64'(l));
    check("R7 user repeated", 64'(d_m_user), 64'(usr));
    check("R5 wide ready", 64'(d_s_ready), 64'(rdy));
    step();
  endtask

  task automatic test_dn_full();
    d_m_ready = 1'b1;
    dn_load(64'h7766_5544_3322_1100, 8'hFF, 1'b1, 2'b10);
    dn_expect("R5 chunk0", 16'h1100, 2'b11, 1'b0, 2'b10, 1'b0);
    dn_expect("R5 chunk1", 16'h3322, 2'b11, 1'b0, 2'b10, 1'b0);
    dn_expect("R5 chunk2", 16'h5544, 2'b11, 1'b0, 2'b10, 1'b0);
    dn_expect("R5 chunk3", 16'h7766, 2'b11, 1'b1, 2'b10, 1'b1);
    #1;
    check("R5 drained", 64'(d_m_valid), 64'd0);
  endtask

  task automatic test_dn_sparse();
    d_m_ready = 1'b1;
    dn_load(64'hDDCC_BBAA_9988_7766, 8'h33, 1'b1, 2'b01);
    dn_expect("R6 skip group1", 16'h7766, 2'b11, 1'b0, 2'b01, 1'b0);
    dn_expect("R6 last on group2", 16'hBBAA, 2'b11, 1'b1, 2'b01, 1'b1);
    #1;
    check("R6 group3 skipped", 64'(d_m_valid), 64'd0);
    dn_load(64'hF0E0_0000_0000_0000, 8'hC0, 1'b0, 2'b11);
    dn_expect("R6 leading skip", 16'hF0E0, 2'b11, 1'b0, 2'b11, 1'b1);
  endtask

  task automatic test_dn_empty();
    d_m_ready = 1'b1;
    dn_load(64'h1234_5678_9ABC_DEF0, 8'h00, 1'b0, 2'b01);
    #1;
    check("R8 empty word dropped", 64'(d_m_valid), 64'd0);
    dn_load(64'h1234_5678_9ABC_DEF0, 8'h00, 1'b1, 2'b10);
    dn_expect("R8 empty last", 16'hDEF0, 2'b00, 1'b1, 2'b10, 1'b1);
  endtask

  task automatic test_dn_backpressure();
    d_m_ready = 1'b0;
    dn_load(64'h4444_3333_2222_1111, 8'hFF, 1'b0, 2'b00);
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R10 dn valid held", 64'(d_m_valid), 64'd1);
      check("R10 dn data held", 64'(d_m_data), 64'h1111);
      check("R5 dn ready low", 64'(d_s_ready), 64'd0);
      step();
    end
    d_m_ready = 1'b1;
    dn_expect("R5 bp chunk0", 16'h1111, 2'b11, 1'b0, 2'b00, 1'b0);
    dn_expect("R5 bp chunk1", 16'h2222, 2'b11, 1'b0, 2'b00, 1'b0);
    dn_expect("R5 bp chunk2", 16'h3333, 2'b11, 1'b0, 2'b00, 1'b0);
    dn_expect("R5 bp chunk3", 16'h4444, 2'b11, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic test_equal();
    e_s_valid = 1'b1; e_s_data = 32'hDEAD_BEEF; e_s_keep = 4'b0110;
    e_s_last = 1'b1; e_s_user = 2'd3; e_m_ready = 1'b0;
    #1;
    check("R9 data", 64'(e_m_data), 64'hDEAD_BEEF);
    check("R9 keep", 64'(e_m_keep), 64'h6);
    check("R9 valid", 64'(e_m_valid), 64'd1);
    check("R9 last", 64'(e_m_last), 64'd1);
    check("R9 user", 64'(e_m_user), 64'd3);
    check("R9 ready low", 64'(e_s_ready), 64'd0);
    e_m_ready = 1'b1;
    #1;
    check("R9 ready high", 64'(e_s_ready), 64'd1);
    e_s_valid = 1'b0;
    #1;
    check("R9 valid low", 64'(e_m_valid), 64'd0);
    step();
  endtask

  initial begin
    up_idle();
    u_m_ready = 1'b0;
    d_s_valid = 1'b0; d_s_data = '0; d_s_keep = '0; d_s_last = 1'b0; d_s_user = '0;
    d_m_ready = 1'b0;
    e_s_valid = 1'b0; e_s_data = '0; e_s_keep = '0; e_s_last = 1'b0; e_s_user = '0;
    e_m_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    test_reset();
    step();
    test_up_full();
    test_up_early_last();
    test_up_backpressure();
    test_dn_full();
    test_dn_sparse();
    test_dn_empty();
    test_dn_backpressure();
    test_equal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule